// File: doc/BRIEF.md
# Run-Time Depth History Buffer

This block delays a valid/data sample stream by a number of samples that is set while the design runs. A scope or logic capture path places it ahead of its DMA. The captured stream then still holds the samples that came just before a trigger. Each accepted sample is stored in an external block RAM, and the sample stored that many accepted samples earlier is read back from the same address. The RAM must have one address port, one cycle of read latency and read-first behaviour. A single-port RAM is enough.

A depth of zero routes the stream around the RAM. Any change on the depth input empties the buffer. After a change the block must store a full depth's worth of samples before the first delayed sample reaches its output. Both paths have the same pipeline length. A sample captured at a clock edge appears on the output two edges later.

Top module: `hist_fifo`

## Requirements
- R1: While reset is high and right after it, `out_valid`, `mem_en` and `mem_we` are low.
- R2: With an effective depth of 0, every accepted input sample is presented on the output unchanged, in order, and no RAM access is made.
- R3: With an effective depth D > 0, counting accepted samples from 0 after the last depth change, sample n with n < D is not forwarded, and sample n with n >= D forwards the data of sample n-D.
- R4: A sample captured at clock edge k shows up on `out_valid`/`out_data` after edge k+2, in both the bypass and the stored path.
- R5: For stored-path sample n, the RAM is accessed after the capture edge with `mem_addr` = n mod D. `mem_wdata` equals the sample. The address therefore wraps at D, not at the RAM size.
- R6: A cycle in which `depth` differs from the value held since the previous edge loads the new depth and clears the write address and the fill count. An input sample presented in that cycle is dropped.
- R7: A `depth` value above MAX_DEPTH behaves exactly like MAX_DEPTH.
- R8: A cycle without `in_valid` causes no RAM access and no output sample. `mem_we` is never high without `mem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| depth | input | DEPTH_W | Requested delay in samples (0 = bypass) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Delayed sample |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM address (read and write) |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after the access |

## Verification
The bench builds the block with MAX_DEPTH = 8 and DATA_W = 8. A 4-bit depth input then reaches every legal depth and also several values above the limit. Every depth from 0 to 8, plus two clamped values, is run under continuous and gapped valid patterns. Each run is entered through a depth change that drops a sample. With a ring of only eight words, every address wrap and every fill-to-forward transition is visited many times. The output timing and each RAM address are predicted from sample counts.

// File: rtl/hist_fifo_pkg.sv
package hist_fifo_pkg;

  // Which pipeline path a sample travels on.
  typedef enum logic {
    PATH_BYPASS = 1'b0,
    PATH_STORE  = 1'b1
  } hist_path_e;

endpackage

// File: rtl/hist_depth_ctrl.sv
module hist_depth_ctrl #(
  parameter int MAX_DEPTH = 8192,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic               change_o,
  output logic               bypass_o,
  output logic [DEPTH_W-1:0] eff_o
);

  localparam logic [DEPTH_W-1:0] MAX_V = DEPTH_W'(MAX_DEPTH);

  logic [DEPTH_W-1:0] raw_q;
  logic [DEPTH_W-1:0] eff_q;

  assign change_o = (depth_i != raw_q);
  assign bypass_o = (eff_q == '0);
  assign eff_o    = eff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      eff_q <= '0;
    end else if (change_o) begin
      raw_q <= depth_i;
      eff_q <= (depth_i > MAX_V) ? MAX_V : depth_i;
    end
  end

  // R6: the held value follows the request one edge after a change
  assert_depth_follows_R6: assert property (@(posedge clk) disable iff (rst)
    change_o |=> (raw_q == $past(depth_i)));

endmodule

// File: rtl/hist_wr_ctrl.sv
module hist_wr_ctrl #(
  parameter int ADDR_W  = 13,
  parameter int DEPTH_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               adv_i,
  input  logic [DEPTH_W-1:0] eff_i,
  output logic [ADDR_W-1:0]  wptr_o,
  output logic               full_o
);

  logic [ADDR_W-1:0]  wptr_q;
  logic [DEPTH_W-1:0] fill_q;
  logic               wrap;

  assign wrap   = (DEPTH_W'(wptr_q) == (eff_i - 1'b1));
  assign full_o = (eff_i != '0) && (fill_q == eff_i);
  assign wptr_o = wptr_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else if (adv_i) begin
      wptr_q <= wrap ? '0 : wptr_q + 1'b1;
      if (!full_o) fill_q <= fill_q + 1'b1;
    end
  end

  assert_ptr_in_ring_R5: assert property (@(posedge clk) disable iff (rst)
    (eff_i != '0) |-> (DEPTH_W'(wptr_q) < eff_i));

  assert_fill_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    fill_q <= eff_i);

  assert_change_clears_R6: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (wptr_q == '0 && fill_q == '0));

endmodule

// File: rtl/hist_out_stage.sv
module hist_out_stage
  import hist_fifo_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_valid_i,
  input  hist_path_e        a_path_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);

  logic              b_valid;
  hist_path_e        b_path;
  logic [DATA_W-1:0] b_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid     <= 1'b0;
      b_path      <= PATH_BYPASS;
      b_data      <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      b_valid     <= a_valid_i;
      b_path      <= a_path_i;
      b_data      <= a_data_i;
      out_valid_o <= b_valid;
      if (b_valid)
        out_data_o <= (b_path == PATH_BYPASS) ? b_data : mem_rdata_i;
    end
  end

  // R4: every output sample left the capture stage two edges earlier
  assert_two_stage_delay_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> $past(a_valid_i, 2));

endmodule

// File: rtl/hist_fifo.sv
module hist_fifo
  import hist_fifo_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_DEPTH = 8192,
  localparam int ADDR_W   = $clog2(MAX_DEPTH),
  localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);

  logic               change;
  logic               bypass;
  logic [DEPTH_W-1:0] eff;
  logic [ADDR_W-1:0]  wptr;
  logic               full;
  logic               adv;

  logic               a_valid;
  hist_path_e         a_path;
  logic [DATA_W-1:0]  a_data;

  hist_depth_ctrl #(
    .MAX_DEPTH (MAX_DEPTH),
    .DEPTH_W   (DEPTH_W)
  ) i_depth (
    .clk      (clk),
    .rst      (rst),
    .depth_i  (depth),
    .change_o (change),
    .bypass_o (bypass),
    .eff_o    (eff)
  );

  assign adv = in_valid && !change && !bypass;

  hist_wr_ctrl #(
    .ADDR_W  (ADDR_W),
    .DEPTH_W (DEPTH_W)
  ) i_wr (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (change),
    .adv_i  (adv),
    .eff_i  (eff),
    .wptr_o (wptr),
    .full_o (full)
  );

  // Capture stage: RAM command and the path tag of the sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      a_valid   <= 1'b0;
      a_path    <= PATH_BYPASS;
      a_data    <= '0;
    end else begin
      mem_en  <= adv;
      mem_we  <= adv;
      if (adv) begin
        mem_addr  <= wptr;
        mem_wdata <= in_data;
      end
      a_valid <= in_valid && !change && (bypass || full);
      a_path  <= bypass ? PATH_BYPASS : PATH_STORE;
      if (in_valid) a_data <= in_data;
    end
  end

  hist_out_stage #(
    .DATA_W (DATA_W)
  ) i_out (
    .clk         (clk),
    .rst         (rst),
    .a_valid_i   (a_valid),
    .a_path_i    (a_path),
    .a_data_i    (a_data),
    .mem_rdata_i (mem_rdata),
    .out_valid_o (out_valid),
    .out_data_o  (out_data)
  );

  assert_we_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  assert_access_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> $past(in_valid));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !mem_en));

endmodule

// File: tb/test_hist_fifo.sv
module test_hist_fifo;

  localparam int DATA_W    = 8;
  localparam int MAX_DEPTH = 8;
  localparam int ADDR_W    = $clog2(MAX_DEPTH);
  localparam int DEPTH_W   = $clog2(MAX_DEPTH + 1);
  localparam int RING      = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [DEPTH_W-1:0] depth = '0;
  logic               in_valid = 1'b0;
  logic [DATA_W-1:0]  in_data = '0;
  logic               out_valid;
  logic [DATA_W-1:0]  out_data;
  logic               mem_en;
  logic               mem_we;
  logic [ADDR_W-1:0]  mem_addr;
  logic [DATA_W-1:0]  mem_wdata;
  logic [DATA_W-1:0]  mem_rdata = '0;

  always #4 clk = ~clk;

  hist_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) i_hist_fifo (
    .clk(clk), .rst(rst), .depth(depth), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Read-first RAM with one cycle of read latency.
  logic [DATA_W-1:0] ram [MAX_DEPTH];
  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= ram[mem_addr];
      if (mem_we) ram[mem_addr] <= mem_wdata;
    end
  end

  int pcount = 0;
  always @(posedge clk) pcount <= pcount + 1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected port values, indexed by posedge count mod RING.
  bit                exp_v  [RING];
  logic [DATA_W-1:0] exp_d  [RING];
  string             exp_t  [RING];
  bit                exp_en [RING];
  logic [DATA_W-1:0] exp_a  [RING];
  logic [DATA_W-1:0] exp_w  [RING];

  // Reference state
  int                m_dep = 0;
  int                m_n   = 0;
  logic [DATA_W-1:0] hist [RING];

  task automatic check(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", tag, what, act, expv, pcount);
    end
  endtask

  task automatic step(input bit v, input logic [DATA_W-1:0] d, input int dep, input string tag);
    int t, s, e, eff;
    @(negedge clk);
    t = pcount;
    s = t % RING;
    check(exp_t[s], "out_valid", int'(out_valid), int'(exp_v[s]));
    if (exp_v[s]) check(exp_t[s], "out_data", int'(out_data), int'(exp_d[s]));
    check(exp_en[s] ? "R5" : "R8", "mem_en", int'(mem_en), int'(exp_en[s]));
    check("R8", "mem_we", int'(mem_we), int'(exp_en[s]));
    if (exp_en[s]) begin
      check("R5", "mem_addr", int'(mem_addr), int'(exp_a[s]));
      check("R5", "mem_wdata", int'(mem_wdata), int'(exp_w[s]));
    end
    exp_v[s] = 0; exp_en[s] = 0; exp_t[s] = "R8";
    in_valid = v;
    in_data  = d;
    depth    = DEPTH_W'(dep);
    e = (t + 3) % RING;
    if (dep != m_dep) begin
      m_dep = dep;                  // R6: pointer reset, this sample dropped
      m_n   = 0;
      exp_t[e] = "R6";
    end else if (v) begin
      eff = (dep > MAX_DEPTH) ? MAX_DEPTH : dep;
      if (eff == 0) begin           // R2 bypass
        exp_v[e] = 1; exp_d[e] = d; exp_t[e] = tag;
      end else begin
        exp_en[(t + 1) % RING] = 1;
        exp_a[(t + 1) % RING]  = DATA_W'(m_n % eff);
        exp_w[(t + 1) % RING]  = d;
        hist[m_n % RING] = d;
        if (m_n >= eff) begin
          exp_v[e] = 1; exp_d[e] = hist[(m_n - eff) % RING]; exp_t[e] = tag;
        end else begin
          exp_t[e] = "R3";          // fill phase, nothing forwarded
        end
        m_n++;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < RING; i++) begin
      exp_v[i] = 0; exp_en[i] = 0; exp_t[i] = "R1"; exp_d[i] = '0; exp_a[i] = '0; exp_w[i] = '0;
    end
    for (int i = 0; i < MAX_DEPTH; i++) ram[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "mem_en in reset", int'(mem_en), 0);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, '0, 0, "R1");

    for (int dep = 0; dep <= 10; dep++) begin
      int dv;
      string tg_c, tg_g;
      dv   = (dep <= MAX_DEPTH) ? dep : ((dep == 9) ? 11 : 15);   // R7 clamp values
      tg_c = (dv == 0) ? "R2" : ((dv > MAX_DEPTH) ? "R7" : "R4");
      tg_g = (dv == 0) ? "R2" : ((dv > MAX_DEPTH) ? "R7" : "R3");
      // entering a new depth with valid high: sample dropped (R6)
      step(1'b1, 8'hEE, dv, "R6");
      for (int i = 0; i < 30; i++)
        step(1'b1, DATA_W'(dv * 37 + i * 5), dv, tg_c);
      for (int i = 0; i < 36; i++)
        step((i % 3) != 0, DATA_W'(dv * 11 + i * 3 + 1), dv, tg_g);
    end

    // Change mid-stream and back: refill after each change (R6)
    for (int i = 0; i < 12; i++) step(1'b1, DATA_W'(i + 100), 3, "R6");
    for (int i = 0; i < 12; i++) step(1'b1, DATA_W'(i + 140), 5, "R6");
    for (int i = 0; i < 12; i++) step(1'b1, DATA_W'(i + 180), 3, "R6");
    for (int i = 0; i < 8; i++)  step(1'b0, '0, 3, "R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule